// File: doc/BRIEF.md
# Baud Divisor Search Engine

This block turns a kernel clock frequency and a wanted serial bit rate into the settings a UART baud generator needs: a prescaler code, an oversampling mode and a packed 16-bit divisor word. It also reports the clock that remains after the prescaler. A single start pulse launches the work. The engine then tries prescaler codes one at a time, from the smallest divide ratio upward, and stops at the first code whose divisor word fits in 16 bits.

Each trial makes two round-to-nearest divisions. One shared sequential divider handles both, producing one quotient bit per cycle. A trial therefore costs about 74 cycles, and a full search of all twelve codes costs under 900 cycles. When the engine has a result it raises `done` for one cycle. At the same moment the result registers update, and they keep their values until the next accepted request completes.

The sequencer has these states:

| State | Role |
|---|---|
| S_IDLE | Waits for a start. |
| S_RANGE | Checks that the requested rate is in range. |
| S_PRE_GO | Launches the prescale division. |
| S_PRE_WAIT | Waits for the prescale division to finish. |
| S_DIV_GO | Launches the divisor division. |
| S_DIV_WAIT | Waits for the divisor division to finish. |
| S_EVAL | Judges the result of the current trial. |
| S_REPORT | Raises the done pulse. |

Its transitions are:

| From | To | Condition |
|---|---|---|
| S_IDLE | S_REPORT | Start with a zero baud. |
| S_IDLE | S_RANGE | Any other start. |
| S_RANGE | S_REPORT | The rate is too fast. |
| S_RANGE | S_PRE_GO | The rate is in range. |
| S_PRE_GO | S_PRE_WAIT | Always. |
| S_PRE_WAIT | S_DIV_GO | The divider finishes. |
| S_DIV_GO | S_DIV_WAIT | Always. |
| S_DIV_WAIT | S_EVAL | The divider finishes. |
| S_EVAL | S_REPORT | The word fits, prescaling is disabled, or the last code has been tried. |
| S_EVAL | S_PRE_GO | Otherwise; the code is incremented. |
| S_REPORT | S_IDLE | Always. |

Top module: `baud_search`

## Requirements
- R1: Codes are tried in rising order, 0 to 11, with divide ratios 1, 2, 4, 6, 8, 10, 12, 16, 32, 64, 128 and 256. The first code whose word fits is reported on `presc_code`.
- R2: For the trial code with ratio r, the prescaled clock is floor((clk_hz + floor(r/2)) / r). A half therefore rounds up. The value of the reported code appears on `clk_pres`.
- R3: The divisor is floor((prescaled + floor(baud/2)) / baud).
- R4: A divisor below 16 selects 8x oversampling and sets `over8` to 1. Any other divisor selects 16x and clears `over8`. The packed word is ((divisor / m) << 4) | (divisor mod m), where m is the oversampling factor.
- R5: A packed word below 65536 ends the search with `err` = 0.
- R6: If code 11 still does not fit, the engine sets `err` = 1 and reports code 11, the low 16 bits of its packed word, and its prescaled clock.
- R7: With `presc_en` = 0, if code 0 does not fit, the engine sets `err` = 1 and reports code 0, the low 16 bits of the packed word and the prescaled clock for code 0. No other code is tried.
- R8: A zero baud, or a baud above clk_hz/8, gives `done` with `err` = 1 and with `presc_code`, `over8`, `brr` and `clk_pres` all 0. No search is run.
- R9: `done` lasts exactly one cycle. The result outputs change only in a cycle where `done` is high.
- R10: A start that arrives while the engine is not idle, including in the `done` cycle itself, is ignored. It produces no `done` and does not change the result.
- R11: After reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only while idle |
| clk_hz | input | 32 | Kernel clock frequency in Hz |
| baud | input | 32 | Requested bit rate |
| presc_en | input | 1 | Allows nonzero prescaler codes |
| done | output | 1 | One-cycle result strobe |
| err | output | 1 | The request could not be met |
| presc_code | output | 4 | Chosen prescaler code |
| over8 | output | 1 | 1 selects 8x oversampling, 0 selects 16x |
| brr | output | 16 | Packed divisor word |
| clk_pres | output | 32 | Clock after the prescaler |

## Verification
Two events can meet in one cycle: a new start request and the completion of the current search. A start can also land while the shared divider is halfway through a quotient. The bench raises `start` in the very cycle it sees `done` high, and separately pulses `start` with different operands partway through a long multi-code search. It judges both cases the same way. The reported result must equal the bench model's answer for the first request. The outputs must stay unchanged afterwards. No further `done` may appear for a long window after either stray start.

// File: rtl/baud_search_pkg.sv
package baud_search_pkg;

    localparam int PRESC_W   = 4;
    localparam int CODE_LAST = 11;
    localparam int RATIO_W   = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RANGE,
        S_PRE_GO,
        S_PRE_WAIT,
        S_DIV_GO,
        S_DIV_WAIT,
        S_EVAL,
        S_REPORT
    } bs_state_t;

    // Divide ratio selected by each prescaler code.
    function automatic logic [RATIO_W-1:0] presc_ratio(input logic [PRESC_W-1:0] code);
        logic [RATIO_W-1:0] r;
        case (code)
            4'd0:    r = 9'd1;
            4'd1:    r = 9'd2;
            4'd2:    r = 9'd4;
            4'd3:    r = 9'd6;
            4'd4:    r = 9'd8;
            4'd5:    r = 9'd10;
            4'd6:    r = 9'd12;
            4'd7:    r = 9'd16;
            4'd8:    r = 9'd32;
            4'd9:    r = 9'd64;
            4'd10:   r = 9'd128;
            default: r = 9'd256;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/baud_div_seq.sv
module baud_div_seq #(
    parameter int NW = 33,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [NW-1:0] num,
    input  logic [DW-1:0] den,
    output logic          busy,
    output logic          done,
    output logic [NW-1:0] quo
);
    localparam int CW = $clog2(NW + 1);
    localparam int PW = NW + DW;

    logic [DW:0]   rem_q;
    logic [DW-1:0] den_q;
    logic [NW-1:0] num_q;
    logic [CW-1:0] cnt_q;
    logic [DW:0]   trial;

    assign busy  = (cnt_q != '0);
    assign trial = {rem_q[DW-1:0], quo[NW-1]};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
            den_q <= '0;
            num_q <= '0;
            quo   <= '0;
            cnt_q <= '0;
            done  <= 1'b0;
        end else if (start) begin
            rem_q <= '0;
            den_q <= den;
            num_q <= num;
            quo   <= num;
            cnt_q <= CW'(NW);
            done  <= 1'b0;
        end else if (busy) begin
            if (trial >= {1'b0, den_q}) begin
                rem_q <= trial - {1'b0, den_q};
                quo   <= {quo[NW-2:0], 1'b1};
            end else begin
                rem_q <= trial;
                quo   <= {quo[NW-2:0], 1'b0};
            end
            cnt_q <= cnt_q - 1'b1;
            done  <= (cnt_q == CW'(1));
        end else begin
            done <= 1'b0;
        end
    end

    // R3: quotient and remainder reproduce the operands at completion
    p_div_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((PW'(quo) * PW'(den_q) + PW'(rem_q)) == PW'(num_q)) && (rem_q < {1'b0, den_q}));

    // R9: divider completion is a single-cycle strobe
    p_div_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

endmodule

// File: rtl/baud_pack.sv
module baud_pack #(
    parameter int NW = 33,
    parameter int BW = 16
) (
    input  logic [NW-1:0] divv,
    output logic          over8,
    output logic [BW-1:0] packed_lo,
    output logic          fits
);
    localparam int FW = NW + 4;

    logic [NW-1:0] mant;
    logic [3:0]    frac;
    logic [FW-1:0] full;

    always_comb begin
        over8 = (divv < NW'(16));
        if (over8) begin
            mant = divv >> 3;
            frac = {1'b0, divv[2:0]};
        end else begin
            mant = divv >> 4;
            frac = divv[3:0];
        end
        full      = {mant, 4'b0000} | FW'(frac);
        packed_lo = full[BW-1:0];
        fits      = ((full >> BW) == '0);
    end

endmodule

// File: rtl/baud_search.sv
module baud_search
    import baud_search_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int BRR_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [DATA_W-1:0]   clk_hz,
    input  logic [DATA_W-1:0]   baud,
    input  logic                presc_en,
    output logic                done,
    output logic                err,
    output logic [PRESC_W-1:0]  presc_code,
    output logic                over8,
    output logic [BRR_W-1:0]    brr,
    output logic [DATA_W-1:0]   clk_pres
);
    localparam int NUM_W = DATA_W + 1;
    localparam int RNG_W = DATA_W + 3;

    bs_state_t state_q, state_n;

    logic [DATA_W-1:0]  clk_q, baud_q, cpres_q;
    logic               pen_q;
    logic [PRESC_W-1:0] code_q;
    logic [NUM_W-1:0]   divv_q;

    logic               dv_start, dv_busy, dv_done;
    logic [NUM_W-1:0]   dv_num, dv_quo;
    logic [DATA_W-1:0]  dv_den;
    logic [RATIO_W-1:0] ratio;

    logic               pk_over8, pk_fits;
    logic [BRR_W-1:0]   pk_word;
    logic               too_fast, last_code, stop_search;

    assign ratio       = presc_ratio(code_q);
    assign too_fast    = ((RNG_W'(baud_q) << 3) > RNG_W'(clk_q));
    assign last_code   = (code_q == PRESC_W'(CODE_LAST));
    assign stop_search = pk_fits || !pen_q || last_code;

    // Shared divider operand selection
    always_comb begin
        dv_start = (state_q == S_PRE_GO) || (state_q == S_DIV_GO);
        if (state_q == S_PRE_GO) begin
            dv_num = NUM_W'(clk_q) + NUM_W'(ratio >> 1);
            dv_den = DATA_W'(ratio);
        end else begin
            dv_num = NUM_W'(cpres_q) + NUM_W'(baud_q >> 1);
            dv_den = baud_q;
        end
    end

    baud_div_seq #(.NW(NUM_W), .DW(DATA_W)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .start (dv_start),
        .num   (dv_num),
        .den   (dv_den),
        .busy  (dv_busy),
        .done  (dv_done),
        .quo   (dv_quo)
    );

    baud_pack #(.NW(NUM_W), .BW(BRR_W)) u_pack (
        .divv      (divv_q),
        .over8     (pk_over8),
        .packed_lo (pk_word),
        .fits      (pk_fits)
    );

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE:     if (start) state_n = (baud == '0) ? S_REPORT : S_RANGE;
            S_RANGE:    state_n = too_fast ? S_REPORT : S_PRE_GO;
            S_PRE_GO:   state_n = S_PRE_WAIT;
            S_PRE_WAIT: if (dv_done) state_n = S_DIV_GO;
            S_DIV_GO:   state_n = S_DIV_WAIT;
            S_DIV_WAIT: if (dv_done) state_n = S_EVAL;
            S_EVAL:     state_n = stop_search ? S_REPORT : S_PRE_GO;
            S_REPORT:   state_n = S_IDLE;
            default:    state_n = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // Request capture and search datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            clk_q   <= '0;
            baud_q  <= '0;
            pen_q   <= 1'b0;
            code_q  <= '0;
            cpres_q <= '0;
            divv_q  <= '0;
        end else begin
            if (state_q == S_IDLE && start) begin
                clk_q  <= clk_hz;
                baud_q <= baud;
                pen_q  <= presc_en;
                code_q <= '0;
            end
            if (state_q == S_PRE_WAIT && dv_done) cpres_q <= dv_quo[DATA_W-1:0];
            if (state_q == S_DIV_WAIT && dv_done) divv_q  <= dv_quo;
            if (state_q == S_EVAL && !stop_search) code_q <= code_q + 1'b1;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done       <= 1'b0;
            err        <= 1'b0;
            presc_code <= '0;
            over8      <= 1'b0;
            brr        <= '0;
            clk_pres   <= '0;
        end else begin
            done <= (state_n == S_REPORT);
            if (state_n == S_REPORT) begin
                if (state_q == S_EVAL) begin
                    err        <= !pk_fits;
                    presc_code <= code_q;
                    over8      <= pk_over8;
                    brr        <= pk_word;
                    clk_pres   <= cpres_q;
                end else begin
                    err        <= 1'b1;
                    presc_code <= '0;
                    over8      <= 1'b0;
                    brr        <= '0;
                    clk_pres   <= '0;
                end
            end
        end
    end

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9: results move only together with done
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(brr) && $stable(presc_code) && $stable(err) && $stable(clk_pres));

    // R1: reported code never passes the last table entry
    p_code_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        presc_code <= PRESC_W'(CODE_LAST));

    // R1: a new trial always follows the previous code by one
    p_code_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_PRE_GO && $past(state_q) == S_EVAL) |-> (code_q == $past(code_q) + 1'b1));

    // R4: 8x mode means a divisor of 8..15, so mantissa 1 and fraction below 8
    p_over8_shape_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && over8) |-> (brr[BRR_W-1:4] == '0 + 1'b1) && !brr[3]);

    // R7: without prescaler support only code 0 is ever reported
    p_noprescale_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !pen_q) |-> (presc_code == '0));

    // R10: a start while busy leaves the captured request untouched
    p_busy_ignore_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && start) |=> $stable(clk_q) && $stable(baud_q));

endmodule

// File: tb/sim_baud_search.sv
`timescale 1ns/1ps
module sim_baud_search;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] clk_hz = '0;
    logic [31:0] baud = '0;
    logic        presc_en = 1'b0;
    logic        done, err, over8;
    logic [3:0]  presc_code;
    logic [15:0] brr;
    logic [31:0] clk_pres;

    int errors = 0;
    int checks = 0;

    always #5 clk = ~clk;

    baud_search u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .clk_hz(clk_hz), .baud(baud),
        .presc_en(presc_en), .done(done), .err(err), .presc_code(presc_code),
        .over8(over8), .brr(brr), .clk_pres(clk_pres)
    );

    function automatic longint unsigned tb_ratio(input int k);
        case (k)
            0: return 1;    1: return 2;    2: return 4;    3: return 6;
            4: return 8;    5: return 10;   6: return 12;   7: return 16;
            8: return 32;   9: return 64;   10: return 128;
            default: return 256;
        endcase
    endfunction

    // Independent model of the requirements
    task automatic model(input longint unsigned c, input longint unsigned b, input bit pe,
                         output int e_code, output bit e_o8, output longint unsigned e_brr,
                         output longint unsigned e_cp, output bit e_err);
        longint unsigned d, m, p;
        e_code = 0; e_o8 = 0; e_brr = 0; e_cp = 0; e_err = 1;
        if (b == 0 || b * 8 > c) return;
        for (int k = 0; k < 12; k++) begin
            e_cp   = (c + tb_ratio(k) / 2) / tb_ratio(k);
            d      = (e_cp + b / 2) / b;
            e_o8   = (d < 16);
            m      = e_o8 ? 8 : 16;
            p      = ((d / m) << 4) | (d % m);
            e_brr  = p & 64'hFFFF;
            e_code = k;
            if (p < 65536) begin e_err = 0; return; end
            if (!pe || k == 11) begin e_err = 1; return; end
        end
    endtask

    task automatic chk(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    // Drive one request, wait for done, compare against the model
    task automatic run(input longint unsigned c, input longint unsigned b, input bit pe,
                       input string req);
        int e_code; bit e_o8; bit e_err; longint unsigned e_brr, e_cp;
        int waited = 0;
        model(c, b, pe, e_code, e_o8, e_brr, e_cp, e_err);
        @(negedge clk);
        clk_hz = c[31:0]; baud = b[31:0]; presc_en = pe; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && waited < 3000) begin
            @(negedge clk);
            waited++;
        end
        chk(req, "done seen", done, 1);
        chk(req, "err", err, e_err);
        chk(req, "presc_code", presc_code, e_code);
        chk(req, "over8", over8, e_o8);
        chk(req, "brr", brr, e_brr);
        chk(req, "clk_pres", clk_pres, e_cp);
        @(negedge clk);
        chk("R9", "done single cycle", done, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=expired expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11: reset state
        chk("R11", "done", done, 0);
        chk("R11", "err", err, 0);
        chk("R11", "brr", brr, 0);
        chk("R11", "clk_pres", clk_pres, 0);
        chk("R11", "code/over8", {presc_code, over8}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R8: zero baud and too-fast requests
        run(64'd48000000, 64'd0, 1, "R8");
        run(64'd8000, 64'd1001, 1, "R8");
        // R4: exact boundary at clk/8 gives divisor 8 in 8x mode
        run(64'd8000, 64'd1000, 1, "R4");
        chk("R4", "over8 at divisor 8", over8, 1);
        chk("R4", "brr at divisor 8", brr, 16'h0010);
        // R4: divisor 16 selects 16x
        run(64'd16000, 64'd1000, 1, "R4");
        chk("R4", "over8 at divisor 16", over8, 0);
        // R5: largest word that fits at code 0
        run(64'd65535, 64'd1, 1, "R5");
        chk("R5", "code 0 fits", presc_code, 0);
        // R1: one past the limit moves to code 1
        run(64'd65536, 64'd1, 1, "R1");
        chk("R1", "code 1 chosen", presc_code, 1);
        // R2: half-up rounding of the prescaled clock
        run(64'd131073, 64'd1, 1, "R2");
        // R3: half-up rounding of the divisor
        run(64'd1500, 64'd100, 1, "R3");
        // R7: prescaler disabled but needed
        run(64'd65536, 64'd1, 0, "R7");
        chk("R7", "err when prescaler needed", err, 1);
        // R6: even code 11 is not enough
        run(64'd4000000000, 64'd1, 1, "R6");
        chk("R6", "code 11 on exhaustion", presc_code, 11);

        // R10: start mid-search, then start in the done cycle
        begin
            int e_code; bit e_o8; bit e_err; longint unsigned e_brr, e_cp;
            int extra = 0;
            model(64'd4000000000, 64'd3, 1, e_code, e_o8, e_brr, e_cp, e_err);
            @(negedge clk);
            clk_hz = 32'd4000000000; baud = 32'd3; presc_en = 1'b1; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            repeat (300) @(negedge clk);
            clk_hz = 32'd50000; baud = 32'd1000; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            while (!done) @(negedge clk);
            start = 1'b1;
            chk("R10", "brr after busy start", brr, e_brr);
            chk("R10", "code after busy start", presc_code, e_code);
            chk("R10", "clk_pres after busy start", clk_pres, e_cp);
            @(negedge clk);
            start = 1'b0;
            for (int i = 0; i < 1000; i++) begin
                @(negedge clk);
                if (done) extra++;
            end
            chk("R10", "no done from ignored starts", extra, 0);
            chk("R9", "brr held while idle", brr, e_brr);
            chk("R9", "code held while idle", presc_code, e_code);
        end

        // R1: constrained random requests
        for (int n = 0; n < 100; n++) begin
            longint unsigned c, b;
            int mode;
            c    = longint'($urandom_range(32'hFFFF_FFFF, 32'd2000));
            mode = int'($urandom_range(3, 0));
            case (mode)
                0: b = longint'($urandom_range(200, 1));
                1: b = longint'($urandom_range(1000000, 1));
                2: begin
                    b = c / 8 - longint'($urandom_range(10, 0));
                    if (b == 0) b = 1;
                end
                default: b = longint'($urandom_range(20000, 1));
            endcase
            run(c, b, $urandom_range(3, 0) != 0, "R1");
        end

        finish_run();
    end

endmodule